// File: doc/BRIEF.md
# Interleaved Dual-Inverter PWM Scheduler

This block runs two three-phase PWM channels from one shared up-down time base. The shared counter traces a triangle, and ownership of whole PWM periods alternates between the two motors. A motor loads its new compare values only at the start of a period it owns. Each motor therefore updates once every two periods, and the two motors update one period apart.

Each motor gives two current-sample positions. These positions are counted in clock cycles from the start of the period. A trigger fires only inside a period owned by that motor, and only in a window that covers the first half of the period plus a fixed margin. Because the two motors' sampling windows fall in different periods, one shared ADC trigger output, tagged with the owning motor, serves both. A motor's control software writes its next duties into a shadow register through a valid/ready port. It has until that motor's next load event to deliver them.

The compare port is the only data stream. A write is taken on a clock edge where valid and ready are both high. Ready drops for exactly one cycle, the last cycle before that motor's load event, so a write can never race the load. A source that sees ready low keeps valid and data steady until the write is taken. All other pins are plain control and status signals.

Top module: `dual_pwm_sched`

## Requirements
- R1: Time base. A position counter runs from 0 to 2P-1 and then returns to 0, so each PWM period lasts 2P clock cycles. The triangle value equals the position while the position is at most P, and equals 2P minus the position after that. After reset the position is 0 and P equals the DEF_PER parameter.
- R2: Period ownership alternates between the motors at every counter wrap. Motor 1 owns the first period after reset. adc_tag_o always shows the current owner: 0 for motor 0, 1 for motor 1.
- R3: upd_o[m] is high for exactly the first cycle (position 0) of each period owned by motor m, except the first period after reset. At most one strobe is high at a time.
- R4: A motor's active duties are copied from its shadow only at the wrap that starts a period it owns. Writes taken at any other time stay hidden until that load. mN_cmp_ready_o is low only in the last cycle of the period just before motor N's own period, and a write is taken when valid and ready are both high. Phase k's duty sits in bits [16k+15:16k] of the compare word.
- R5: Gate bit 2k (high side of phase k) is 1 when the triangle value is below duty k. Gate bit 2k+1 is its complement. All duties are 0 after reset, so only the low sides are on.
- R6: During a period owned by motor m, adc_trig_o is high in each cycle whose position equals one of motor m's two trigger positions, provided that position is valid. A position t is valid when t is at most P+EXT and t is below 2P.
- R7: If either trigger position of the owner is invalid at position 0 of its period, trig_err_o[m] is high for that cycle. An invalid position never produces a trigger. Two equal valid positions produce a single pulse and no flag.
- R8: A motor never triggers in a period owned by the other motor, so the two motors' sampling windows never overlap.
- R9: period_i is sampled at each wrap and sets P for the next period. Values below 2 are taken as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CW | Half-period P in clock cycles, sampled at each wrap |
| m0_cmp_i | input | 3*CW | Motor 0 compare word, three duties |
| m0_cmp_valid_i | input | 1 | Motor 0 compare word valid |
| m0_cmp_ready_o | output | 1 | Motor 0 shadow can accept a word |
| m1_cmp_i | input | 3*CW | Motor 1 compare word |
| m1_cmp_valid_i | input | 1 | Motor 1 compare word valid |
| m1_cmp_ready_o | output | 1 | Motor 1 shadow can accept a word |
| m0_trig_a_i | input | CW+1 | Motor 0 first sample position |
| m0_trig_b_i | input | CW+1 | Motor 0 second sample position |
| m1_trig_a_i | input | CW+1 | Motor 1 first sample position |
| m1_trig_b_i | input | CW+1 | Motor 1 second sample position |
| m0_gate_o | output | 6 | Motor 0 gates: high side at even bits, low side at odd bits |
| m1_gate_o | output | 6 | Motor 1 gates |
| adc_trig_o | output | 1 | Shared converter start pulse |
| adc_tag_o | output | 1 | Motor that owns the current period |
| upd_o | output | 2 | Per-motor load strobes |
| trig_err_o | output | 2 | Per-motor flag for a suppressed trigger position |

## Verification
The assertions take for granted that a source keeps valid and data steady while ready is low, and that period_i and the trigger positions are ordinary binary numbers. These inputs may change at any edge. The stimulus makes each compare write with random data and holds valid until the write is taken. It changes the period only at random times, with values between 2 and 40, and it also drives the clamped values 0 and 1 on purpose. Trigger positions are drawn from a range that reaches past 2P+4, so both valid and invalid positions occur. Directed cases hit the exact window edge P+EXT, the first position past it, equal A and B positions, duty 0, and duties above P.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
  localparam int NPHASE = 3;
  localparam int NMOTOR = 2;
  typedef enum logic {OWNER_M0 = 1'b0, OWNER_M1 = 1'b1} owner_e;
endpackage

// File: rtl/dps_timebase.sv
`timescale 1ns/1ps
module dps_timebase #(
  parameter int CW      = 16,
  parameter int DEF_PER = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  output logic [CW:0]   pos_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic          slot_o,
  output logic          wrap_o
);
  import dps_pkg::*;
  localparam int PW = CW + 1;

  logic [PW-1:0] pos_q, last_w, dbl_w;
  logic [CW-1:0] per_q, per_nxt;
  owner_e        slot_q;

  assign dbl_w   = {per_q, 1'b0};
  assign last_w  = dbl_w - PW'(1);
  assign wrap_o  = (pos_q == last_w);
  assign per_nxt = (period_i < CW'(2)) ? CW'(2) : period_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      per_q  <= CW'(DEF_PER);
      slot_q <= OWNER_M1;
    end else if (wrap_o) begin
      pos_q  <= '0;
      per_q  <= per_nxt;
      slot_q <= (slot_q == OWNER_M0) ? OWNER_M1 : OWNER_M0;
    end else begin
      pos_q  <= pos_q + PW'(1);
    end
  end

  // triangle: rising half then falling half
  assign cnt_o  = (pos_q <= {1'b0, per_q}) ? pos_q[CW-1:0] : CW'(dbl_w - pos_q);
  assign pos_o  = pos_q;
  assign per_o  = per_q;
  assign slot_o = slot_q;

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= last_w); // R1
  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (pos_q == '0)); // R1
  AST_SLOT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (slot_q != $past(slot_q))); // R2
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(per_q)); // R9
endmodule

// File: rtl/dps_channel.sv
`timescale 1ns/1ps
module dps_channel #(
  parameter int CW  = 16,
  parameter int MID = 0,
  parameter int EXT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CW:0]                    pos_i,
  input  logic [CW-1:0]                  cnt_i,
  input  logic [CW-1:0]                  per_i,
  input  logic                           slot_i,
  input  logic                           wrap_i,
  input  logic [dps_pkg::NPHASE*CW-1:0]  cmp_i,
  input  logic                           cmp_valid_i,
  output logic                           cmp_ready_o,
  input  logic [CW:0]                    trig_a_i,
  input  logic [CW:0]                    trig_b_i,
  output logic [2*dps_pkg::NPHASE-1:0]   gate_o,
  output logic                           upd_o,
  output logic                           hit_o,
  output logic                           err_o
);
  import dps_pkg::*;
  localparam int PW = CW + 1;
  localparam int LW = CW + 2;
  localparam logic ME = (MID != 0);

  logic [NPHASE*CW-1:0] shadow_q, act_q;
  logic                 upd_q, load_w, own_w;
  logic                 ok_a, ok_b;
  logic [LW-1:0]        lim_w, dbl_w;

  assign own_w       = (slot_i == ME);
  assign load_w      = wrap_i && !own_w;
  assign cmp_ready_o = !load_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      upd_q    <= 1'b0;
    end else begin
      if (cmp_valid_i && cmp_ready_o) shadow_q <= cmp_i;
      if (load_w) act_q <= shadow_q;
      upd_q <= load_w;
    end
  end
  assign upd_o = upd_q;

  genvar k;
  generate
    for (k = 0; k < NPHASE; k++) begin : g_ph
      logic hi;
      assign hi            = (cnt_i < act_q[k*CW +: CW]);
      assign gate_o[2*k]   = hi;
      assign gate_o[2*k+1] = !hi;
    end
  endgenerate

  assign lim_w = LW'(per_i) + LW'(EXT);
  assign dbl_w = {1'b0, per_i, 1'b0};
  assign ok_a  = (LW'(trig_a_i) <= lim_w) && (LW'(trig_a_i) < dbl_w);
  assign ok_b  = (LW'(trig_b_i) <= lim_w) && (LW'(trig_b_i) < dbl_w);

  assign hit_o = own_w && (((pos_i == trig_a_i) && ok_a) || ((pos_i == trig_b_i) && ok_b));
  assign err_o = own_w && (pos_i == PW'(0)) && !(ok_a && ok_b);

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(act_q)); // R4
  AST_READY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ready_o |=> upd_o); // R4
  AST_UPD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (pos_i == PW'(0)) && own_w); // R3
endmodule

// File: rtl/dual_pwm_sched.sv
`timescale 1ns/1ps
module dual_pwm_sched #(
  parameter int CW      = 16,
  parameter int DEF_PER = 16,
  parameter int EXT     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        period_i,
  input  logic [3*CW-1:0]      m0_cmp_i,
  input  logic                 m0_cmp_valid_i,
  output logic                 m0_cmp_ready_o,
  input  logic [3*CW-1:0]      m1_cmp_i,
  input  logic                 m1_cmp_valid_i,
  output logic                 m1_cmp_ready_o,
  input  logic [CW:0]          m0_trig_a_i,
  input  logic [CW:0]          m0_trig_b_i,
  input  logic [CW:0]          m1_trig_a_i,
  input  logic [CW:0]          m1_trig_b_i,
  output logic [5:0]           m0_gate_o,
  output logic [5:0]           m1_gate_o,
  output logic                 adc_trig_o,
  output logic                 adc_tag_o,
  output logic [1:0]           upd_o,
  output logic [1:0]           trig_err_o
);
  import dps_pkg::*;
  localparam int PW = CW + 1;

  logic [PW-1:0]        pos_w;
  logic [CW-1:0]        cnt_w, per_w;
  logic                 slot_w, wrap_w;
  logic [3*CW-1:0]      cmp_a   [NMOTOR];
  logic                 vld_a   [NMOTOR];
  logic                 rdy_a   [NMOTOR];
  logic [PW-1:0]        ta_a    [NMOTOR];
  logic [PW-1:0]        tb_a    [NMOTOR];
  logic [5:0]           gate_a  [NMOTOR];
  logic [NMOTOR-1:0]    hit_w;

  assign cmp_a[0] = m0_cmp_i;       assign cmp_a[1] = m1_cmp_i;
  assign vld_a[0] = m0_cmp_valid_i; assign vld_a[1] = m1_cmp_valid_i;
  assign ta_a[0]  = m0_trig_a_i;    assign ta_a[1]  = m1_trig_a_i;
  assign tb_a[0]  = m0_trig_b_i;    assign tb_a[1]  = m1_trig_b_i;
  assign m0_cmp_ready_o = rdy_a[0]; assign m1_cmp_ready_o = rdy_a[1];
  assign m0_gate_o = gate_a[0];     assign m1_gate_o = gate_a[1];

  dps_timebase #(.CW(CW), .DEF_PER(DEF_PER)) u_tb (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .pos_o(pos_w), .cnt_o(cnt_w), .per_o(per_w), .slot_o(slot_w), .wrap_o(wrap_w)
  );

  genvar m;
  generate
    for (m = 0; m < NMOTOR; m++) begin : g_mot
      dps_channel #(.CW(CW), .MID(m), .EXT(EXT)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .pos_i(pos_w), .cnt_i(cnt_w), .per_i(per_w), .slot_i(slot_w), .wrap_i(wrap_w),
        .cmp_i(cmp_a[m]), .cmp_valid_i(vld_a[m]), .cmp_ready_o(rdy_a[m]),
        .trig_a_i(ta_a[m]), .trig_b_i(tb_a[m]),
        .gate_o(gate_a[m]), .upd_o(upd_o[m]), .hit_o(hit_w[m]), .err_o(trig_err_o[m])
      );
    end
  endgenerate

  assign adc_trig_o = |hit_w;
  assign adc_tag_o  = slot_w;

  AST_ONE_SAMPLER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w)); // R8
  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o)); // R3
  AST_TRIG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig_o |-> ((CW+2)'(pos_w) <= (CW+2)'(per_w) + (CW+2)'(EXT))); // R6
  AST_ERR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_err_o) |-> (pos_w == '0)); // R7
endmodule

// File: tb/sim_dual_pwm_sched.sv
`timescale 1ns/1ps
module sim_dual_pwm_sched;
  localparam int CW = 16;
  localparam int DEF = 16;
  localparam int EXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] period_i = CW'(DEF);
  logic [3*CW-1:0] m0_cmp_i = '0, m1_cmp_i = '0;
  logic m0_cmp_valid_i = 1'b0, m1_cmp_valid_i = 1'b0;
  logic m0_cmp_ready_o, m1_cmp_ready_o;
  logic [CW:0] m0_trig_a_i = 17'd2, m0_trig_b_i = 17'd10, m1_trig_a_i = 17'd3, m1_trig_b_i = 17'd12;
  logic [5:0] m0_gate_o, m1_gate_o;
  logic adc_trig_o, adc_tag_o;
  logic [1:0] upd_o, trig_err_o;

  always #2.5 clk = ~clk;

  dual_pwm_sched #(.CW(CW), .DEF_PER(DEF), .EXT(EXT)) u0 (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .m0_cmp_i(m0_cmp_i), .m0_cmp_valid_i(m0_cmp_valid_i), .m0_cmp_ready_o(m0_cmp_ready_o),
    .m1_cmp_i(m1_cmp_i), .m1_cmp_valid_i(m1_cmp_valid_i), .m1_cmp_ready_o(m1_cmp_ready_o),
    .m0_trig_a_i(m0_trig_a_i), .m0_trig_b_i(m0_trig_b_i),
    .m1_trig_a_i(m1_trig_a_i), .m1_trig_b_i(m1_trig_b_i),
    .m0_gate_o(m0_gate_o), .m1_gate_o(m1_gate_o),
    .adc_trig_o(adc_trig_o), .adc_tag_o(adc_tag_o), .upd_o(upd_o), .trig_err_o(trig_err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_pos, m_slot, m_per;
  logic [3*CW-1:0] m_sh[2], m_act[2];
  bit m_upd[2];
  bit acc[2];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] gexp(logic [3*CW-1:0] duty, int cnt);
    logic [5:0] g;
    for (int k = 0; k < 3; k++) begin
      g[2*k]   = (cnt < int'(duty[k*CW +: CW]));
      g[2*k+1] = !g[2*k];
    end
    return g;
  endfunction

  function automatic bit tok(int t, int per);
    return (t <= per + EXT) && (t < 2 * per);
  endfunction

  task automatic model_reset();
    m_pos = 0; m_slot = 1; m_per = DEF;
    for (int m = 0; m < 2; m++) begin m_sh[m] = '0; m_act[m] = '0; m_upd[m] = 0; end
  endtask

  task automatic step();
    int cnt, ta, tb, nxt;
    bit wrap, etrig, eerr;
    bit rdy[2];
    bit vld[2];
    logic [3*CW-1:0] dat[2];
    #1;
    cnt = (m_pos <= m_per) ? m_pos : 2 * m_per - m_pos;
    chk(m0_gate_o == gexp(m_act[0], cnt), "R1 R5 m0 gates", 64'(m0_gate_o), 64'(gexp(m_act[0], cnt)));
    chk(m1_gate_o == gexp(m_act[1], cnt), "R1 R5 m1 gates", 64'(m1_gate_o), 64'(gexp(m_act[1], cnt)));
    chk(upd_o == {m_upd[1], m_upd[0]}, "R3 R9 update strobes", 64'(upd_o), 64'({m_upd[1], m_upd[0]}));
    ta = (m_slot == 1) ? int'(m1_trig_a_i) : int'(m0_trig_a_i);
    tb = (m_slot == 1) ? int'(m1_trig_b_i) : int'(m0_trig_b_i);
    etrig = ((m_pos == ta) && tok(ta, m_per)) || ((m_pos == tb) && tok(tb, m_per));
    chk(adc_trig_o == etrig, "R6 R8 trigger", 64'(adc_trig_o), 64'(etrig));
    chk(adc_tag_o == m_slot[0], "R2 owner tag", 64'(adc_tag_o), 64'(m_slot));
    eerr = (m_pos == 0) && !(tok(ta, m_per) && tok(tb, m_per));
    chk(trig_err_o == (eerr ? 2'(1 << m_slot) : 2'b00), "R7 trigger flag",
        64'(trig_err_o), 64'(eerr ? (1 << m_slot) : 0));
    wrap = (m_pos == 2 * m_per - 1);
    rdy[0] = !(wrap && m_slot != 0);
    rdy[1] = !(wrap && m_slot != 1);
    chk({m1_cmp_ready_o, m0_cmp_ready_o} == {rdy[1], rdy[0]}, "R4 ready",
        64'({m1_cmp_ready_o, m0_cmp_ready_o}), 64'({rdy[1], rdy[0]}));
    vld[0] = m0_cmp_valid_i; vld[1] = m1_cmp_valid_i;
    dat[0] = m0_cmp_i; dat[1] = m1_cmp_i;
    m_upd[0] = 0; m_upd[1] = 0;
    if (wrap) begin
      nxt = 1 - m_slot;
      m_act[nxt] = m_sh[nxt];
      m_upd[nxt] = 1;
      m_slot = nxt;
      m_pos = 0;
      m_per = (period_i < 2) ? 2 : int'(period_i);
    end else m_pos++;
    for (int m = 0; m < 2; m++) begin
      acc[m] = vld[m] && rdy[m];
      if (acc[m]) m_sh[m] = dat[m];
    end
    @(posedge clk);
    @(negedge clk);
    if (acc[0]) m0_cmp_valid_i = 0;
    if (acc[1]) m1_cmp_valid_i = 0;
  endtask

  function automatic logic [3*CW-1:0] duties(int a, int b, int c);
    return {CW'(c), CW'(b), CW'(a)};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(m0_gate_o == 6'b101010, "R5 reset gates m0", 64'(m0_gate_o), 64'h2a);
    chk(m1_gate_o == 6'b101010, "R5 reset gates m1", 64'(m1_gate_o), 64'h2a);
    chk(upd_o == 2'b00 && adc_trig_o == 1'b0, "R3 reset strobes", 64'({upd_o, adc_trig_o}), 64'h0);
    chk(adc_tag_o == 1'b1, "R2 reset owner", 64'(adc_tag_o), 64'h1);
    @(negedge clk);
    rst_n = 1;
    // directed: duty 0, duty > P, mid values
    m0_cmp_i = duties(5, 20, 0); m0_cmp_valid_i = 1;
    m1_cmp_i = duties(8, 3, 17); m1_cmp_valid_i = 1;
    repeat (110) step();
    // window edge P+EXT valid, P+EXT+1 invalid; equal positions
    m0_trig_a_i = 17'(DEF + EXT); m0_trig_b_i = 17'(DEF + EXT + 1);
    m1_trig_a_i = 17'd7; m1_trig_b_i = 17'd7;
    m0_cmp_i = duties(1, 2, 3); m0_cmp_valid_i = 1;
    repeat (70) step();
    // period changes including clamp
    period_i = 9; repeat (60) step();
    period_i = 1; repeat (20) step();
    period_i = 0; repeat (20) step();
    period_i = 12; repeat (60) step();
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) period_i = CW'(2 + $urandom_range(0, 38));
      if (i % 64 == 0) begin
        m0_trig_a_i = 17'($urandom_range(0, 2 * int'(period_i) + 6));
        m0_trig_b_i = 17'($urandom_range(0, 2 * int'(period_i) + 6));
        m1_trig_a_i = 17'($urandom_range(0, 2 * int'(period_i) + 6));
        m1_trig_b_i = 17'($urandom_range(0, 2 * int'(period_i) + 6));
      end
      if (!m0_cmp_valid_i && $urandom_range(0, 5) == 0) begin
        m0_cmp_i = duties($urandom_range(0, 42), $urandom_range(0, 42), $urandom_range(0, 42));
        m0_cmp_valid_i = 1;
      end
      if (!m1_cmp_valid_i && $urandom_range(0, 5) == 0) begin
        m1_cmp_i = duties($urandom_range(0, 42), $urandom_range(0, 42), $urandom_range(0, 42));
        m1_cmp_valid_i = 1;
      end
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule